// File: doc/BRIEF.md
# PLL Output Post-Divider with Phase Alignment

This block turns the raw oscillator clock of a PLL into the clocks the rest of the chip uses. It receives the oscillator in three phases, 0°, 120° and 240°. Each phase drives its own power-of-two divider, and the 0° divider gives the main output clock. The two extra-phase dividers can be switched on for circuits that need several evenly spaced clock edges. Before the PLL reports lock these two dividers free-run. Once lock arrives they are realigned to the main divider, so each extra output is an exact copy of the main output delayed by one third or two thirds of an oscillator period.

A bypass path sends the oscillator phases straight to the outputs when a higher frequency is needed than the smallest division ratio gives. A power-down control holds every divider cleared and forces the outputs and the lock flag low. After power-down is released the dividers start again, and the lock flag returns once the incoming lock indication has passed through the synchronizer.

Top module: `pll_postdiv`

## Requirements
- R1: With bypass off, a select value s (00, 01, 10, 11) divides the 0° oscillator by 2^(s+1), giving 2, 4, 8 or 16. The main output is high for exactly half of the output period and low for the other half, both counted in oscillator cycles.
- R2: A new select value takes effect only when the current output period has fully completed. Every high or low interval is therefore half of either the old period or the new period, never shorter.
- R3: With bypass on and power-down off, the main output follows the 0° oscillator input directly.
- R4: With phase-enable at 0, both extra-phase outputs stay low. With phase-enable at 1 and bypass off, each extra output is its own oscillator phase divided by the same ratio as the main output, with a 50% duty cycle.
- R5: Before lock, the extra-phase dividers need not match the main divider. After lock, the dividers realign at the first main period boundary. From then on the 120° output equals the main output delayed by one third of an oscillator period, and the 240° output equals it delayed by two thirds, including across select changes.
- R6: While power-down is high, all outputs are low, every divider counter is held at zero, and the lock output goes low one oscillator cycle after power-down is sampled. After release, division resumes with the correct ratio.
- R7: The lock output is the lock input passed through a two-stage synchronizer on the 0° oscillator. It rises two oscillator cycles after the input rises, only while power-down is low, and it falls two cycles after the input falls.
- R8: An active-low asynchronous reset clears all counters at once and drives every clock output and the lock output low.
- R9: With bypass on and phase-enable at 1, each extra-phase output follows its own oscillator phase directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_0 | input | 1 | Oscillator, 0° phase; clocks the main divider |
| osc_120 | input | 1 | Oscillator, 120° phase |
| osc_240 | input | 1 | Oscillator, 240° phase |
| lock_in | input | 1 | Lock indication from the loop (asynchronous) |
| pwr_down | input | 1 | Power-down: clears dividers, forces outputs low |
| direct_en | input | 1 | Bypass: route oscillator phases straight to the outputs |
| phase_en | input | 1 | Enable the two extra-phase outputs |
| div_sel | input | SEL_W | Division select, ratio 2^(div_sel+1) |
| clk_main | output | 1 | Main output clock |
| clk_ph2 | output | 1 | Extra output derived from the 120° phase |
| clk_ph3 | output | 1 | Extra output derived from the 240° phase |
| lock_out | output | 1 | Synchronized lock flag |

## Verification
On every 0° oscillator edge, the assertions check the main divider's own rules: the counter stays within the current ratio, the output toggles only at the start or the middle of a period, the select changes only at a period boundary or under power-down, power-down clears the counter, and the lock flag follows the input through the synchronizer. They cannot see behaviour that spans clock domains. The bench scenarios therefore cover the 120° and 240° outputs before and after lock, including their realignment after power-down, and the exact length of each high and low interval when the select changes mid-period. The bench also covers the bypass paths and the asynchronous reset.

// File: rtl/pll_postdiv_pkg.sv
package pll_postdiv_pkg;

    // Defaults shared by the top and the checker
    localparam int DFLT_SEL_W       = 2;
    localparam int DFLT_SYNC_STAGES = 2;

    // Last count of a period for select value s: 2^(s+1) - 1
    function automatic logic [31:0] wrap_val(input logic [31:0] sel);
        return (32'd1 << (sel + 32'd1)) - 32'd1;
    endfunction

    // Count at which the divided output goes high: 2^s
    function automatic logic [31:0] half_val(input logic [31:0] sel);
        return 32'd1 << sel;
    endfunction

endpackage

// File: rtl/pll_postdiv_sync.sv
module pll_postdiv_sync #(
    parameter int STAGES = pll_postdiv_pkg::DFLT_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        if (clr) begin
            sh_d = '0;
        end else begin
            sh_d = {sh_q[STAGES-2:0], d};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pll_postdiv_phase.sv
module pll_postdiv_phase #(
    parameter int SEL_W       = pll_postdiv_pkg::DFLT_SEL_W,
    parameter int SYNC_STAGES = pll_postdiv_pkg::DFLT_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             align_i,
    output logic             div_o
);
    import pll_postdiv_pkg::*;

    localparam int CNT_W = 1 << SEL_W;
    // The main counter advances once per sync stage before the preload lands
    localparam logic [CNT_W-1:0] LOAD_BASE = CNT_W'(SYNC_STAGES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
        logic             out;
        logic             seen;
    } ph_state_t;

    ph_state_t ph_d, ph_q;
    logic             align_s;
    logic [CNT_W-1:0] wrap;
    logic             tc;
    logic             rise;

    pll_postdiv_sync #(.STAGES(SYNC_STAGES)) u_align_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .d     (align_i),
        .q     (align_s)
    );

    always_comb begin
        wrap = CNT_W'(wrap_val(32'(ph_q.sel)));
        tc   = (ph_q.cnt == wrap);
        rise = align_s & ~ph_q.seen;
        ph_d = ph_q;
        if (clr) begin
            ph_d.cnt  = '0;
            ph_d.sel  = sel_i;
            ph_d.seen = 1'b0;
        end else begin
            ph_d.seen = align_s;
            if (rise) begin
                ph_d.cnt = LOAD_BASE & wrap;
            end else if (tc) begin
                ph_d.cnt = '0;
                ph_d.sel = sel_i;
            end else begin
                ph_d.cnt = ph_q.cnt + CNT_W'(1);
            end
        end
        ph_d.out = clr ? 1'b0 : ph_d.cnt[ph_d.sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign div_o = ph_q.out;
endmodule

// File: rtl/pll_postdiv.sv
module pll_postdiv #(
    parameter int SEL_W       = pll_postdiv_pkg::DFLT_SEL_W,
    parameter int SYNC_STAGES = pll_postdiv_pkg::DFLT_SYNC_STAGES
) (
    input  logic             rst_n,
    input  logic             osc_0,
    input  logic             osc_120,
    input  logic             osc_240,
    input  logic             lock_in,
    input  logic             pwr_down,
    input  logic             direct_en,
    input  logic             phase_en,
    input  logic [SEL_W-1:0] div_sel,
    output logic             clk_main,
    output logic             clk_ph2,
    output logic             clk_ph3,
    output logic             lock_out
);
    import pll_postdiv_pkg::*;

    localparam int CNT_W  = 1 << SEL_W;
    localparam int N_PHAS = 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
        logic             out;
        logic             aligned;
    } main_state_t;

    main_state_t m_d, m_q;
    logic             lock_s;
    logic [CNT_W-1:0] main_wrap;
    logic             main_tc;

    // Lock flag into the 0° domain
    pll_postdiv_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
        .clk   (osc_0),
        .rst_n (rst_n),
        .clr   (pwr_down),
        .d     (lock_in),
        .q     (lock_s)
    );

    always_comb begin
        main_wrap = CNT_W'(wrap_val(32'(m_q.sel)));
        main_tc   = (m_q.cnt == main_wrap);
        m_d       = m_q;
        if (pwr_down) begin
            m_d.cnt     = '0;
            m_d.sel     = div_sel;
            m_d.aligned = 1'b0;
        end else begin
            if (main_tc) begin
                m_d.cnt = '0;
                m_d.sel = div_sel;
            end else begin
                m_d.cnt = m_q.cnt + CNT_W'(1);
            end
            if (!lock_s || !phase_en) begin
                m_d.aligned = 1'b0;
            end else if (main_tc) begin
                m_d.aligned = 1'b1;
            end
        end
        m_d.out = pwr_down ? 1'b0 : m_d.cnt[m_d.sel];
    end

    always_ff @(posedge osc_0 or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    // Extra-phase channels
    logic [N_PHAS-1:0] ph_clk;
    logic [N_PHAS-1:0] ph_div;
    logic [N_PHAS-1:0] ph_out;

    assign ph_clk = {osc_240, osc_120};

    for (genvar g = 0; g < N_PHAS; g++) begin : g_phase
        pll_postdiv_phase #(
            .SEL_W       (SEL_W),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_phase (
            .clk     (ph_clk[g]),
            .rst_n   (rst_n),
            .clr     (pwr_down | ~phase_en),
            .sel_i   (m_q.sel),
            .align_i (m_q.aligned),
            .div_o   (ph_div[g])
        );
        assign ph_out[g] = ~pwr_down & phase_en & (direct_en ? ph_clk[g] : ph_div[g]);
    end

    assign clk_main = ~pwr_down & (direct_en ? osc_0 : m_q.out);
    assign clk_ph2  = ph_out[0];
    assign clk_ph3  = ph_out[1];
    assign lock_out = lock_s;
endmodule

// File: rtl/pll_postdiv_chk.sv
module pll_postdiv_chk #(
    parameter int SEL_W = pll_postdiv_pkg::DFLT_SEL_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    pwr_down,
    input logic                    lock_in,
    input logic                    lock_out,
    input logic [(1<<SEL_W)-1:0]   main_cnt,
    input logic [SEL_W-1:0]        main_sel,
    input logic                    main_out,
    input logic                    main_tc
);
    import pll_postdiv_pkg::*;

    localparam int CNT_W = 1 << SEL_W;

    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] mid;
    assign lim = CNT_W'(wrap_val(32'(main_sel)));
    assign mid = CNT_W'(half_val(32'(main_sel)));

    // R1
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        main_cnt <= lim);

    // R1
    toggle_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(main_out) && !$past(pwr_down) |-> (main_cnt == '0) || (main_cnt == mid));

    // R2
    sel_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(main_sel) |-> $past(main_tc) || $past(pwr_down));

    // R6
    pd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (main_cnt == '0) && !main_out && !lock_out);

    // R7
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_out) |-> $past(lock_in, 2) && !$past(pwr_down));

    // R8
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_low_chk: assert (!lock_out && !main_out && main_cnt == '0);
        end
    end
endmodule

bind pll_postdiv pll_postdiv_chk #(.SEL_W(SEL_W)) u_chk (
    .clk      (osc_0),
    .rst_n    (rst_n),
    .pwr_down (pwr_down),
    .lock_in  (lock_in),
    .lock_out (lock_out),
    .main_cnt (m_q.cnt),
    .main_sel (m_q.sel),
    .main_out (m_q.out),
    .main_tc  (main_tc)
);

// File: tb/test_pll_postdiv.sv
module test_pll_postdiv;
    timeunit 1ps;
    timeprecision 1ps;

    localparam time T = 5000;  // 200 MHz

    logic       rst_n = 1'b0;
    logic       osc_0 = 1'b0, osc_120 = 1'b0, osc_240 = 1'b0;
    logic       lock_in = 1'b0, pwr_down = 1'b0, direct_en = 1'b0, phase_en = 1'b0;
    logic [1:0] div_sel = 2'd0;
    logic       clk_main, clk_ph2, clk_ph3, lock_out;

    int n_chk = 0;
    int n_bad = 0;

    always #(T/2) osc_0 = ~osc_0;
    always @(osc_0) osc_120 <= #1667 osc_0;
    always @(osc_0) osc_240 <= #3333 osc_0;

    pll_postdiv i_pll_postdiv (
        .rst_n     (rst_n),
        .osc_0     (osc_0),
        .osc_120   (osc_120),
        .osc_240   (osc_240),
        .lock_in   (lock_in),
        .pwr_down  (pwr_down),
        .direct_en (direct_en),
        .phase_en  (phase_en),
        .div_sel   (div_sel),
        .clk_main  (clk_main),
        .clk_ph2   (clk_ph2),
        .clk_ph3   (clk_ph3),
        .lock_out  (lock_out)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Scoreboard: main samples pushed, phase samples popped and compared
    logic cmp_on = 1'b0;
    logic strict = 1'b0;
    int   mis = 0;
    logic q2[$];
    logic q3[$];

    always @(negedge osc_0) begin
        if (cmp_on) begin
            q2.push_back(clk_main);
            q3.push_back(clk_main);
        end
    end

    always @(negedge osc_120) begin
        logic v;
        if (q2.size() > 0) begin
            v = q2.pop_front();
            if (strict) check_eq("R5 ph2 tracks main", int'(clk_ph2), int'(v));
            else if (v != clk_ph2) mis++;
        end
    end

    always @(negedge osc_240) begin
        logic v;
        if (q3.size() > 0) begin
            v = q3.pop_front();
            if (strict) check_eq("R5 ph3 tracks main", int'(clk_ph3), int'(v));
            else if (v != clk_ph3) mis++;
        end
    end

    task automatic sample(input int which, output logic v);
        case (which)
            0:       begin @(negedge osc_0);   v = clk_main; end
            1:       begin @(negedge osc_120); v = clk_ph2;  end
            default: begin @(negedge osc_240); v = clk_ph3;  end
        endcase
    endtask

    // Length of one high run and the following low run, in oscillator cycles
    task automatic runs(input int which, output int hi, output int lo);
        logic p, v;
        int   guard;
        hi = 0; lo = 0; guard = 0;
        sample(which, p);
        sample(which, v);
        while (!(p == 1'b0 && v == 1'b1) && guard < 100) begin
            p = v; sample(which, v); guard++;
        end
        while (v == 1'b1 && guard < 200) begin hi++; sample(which, v); guard++; end
        while (v == 1'b0 && guard < 300) begin lo++; sample(which, v); guard++; end
    endtask

    task automatic compare_for(input int cycles, input logic is_strict);
        @(negedge osc_0); #100;
        strict = is_strict;
        cmp_on = 1'b1;
        repeat (cycles) @(negedge osc_0);
        #100 cmp_on = 1'b0;
        repeat (2) @(negedge osc_0);
        q2.delete(); q3.delete();
    endtask

    initial begin
        #(T * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int hi, lo;
        logic v;

        // R8 reset state
        repeat (3) @(negedge osc_0);
        check_eq("R8 reset clk_main", int'(clk_main), 0);
        check_eq("R8 reset clk_ph2", int'(clk_ph2), 0);
        check_eq("R8 reset clk_ph3", int'(clk_ph3), 0);
        check_eq("R8 reset lock_out", int'(lock_out), 0);
        rst_n = 1'b1;

        // R1 all ratios, R4 extra outputs low while disabled
        for (int s = 0; s < 4; s++) begin
            div_sel = 2'(s);
            repeat (40) @(negedge osc_0);
            runs(0, hi, lo);
            check_eq("R1 high run", hi, (1 << (s + 1)) / 2);
            check_eq("R1 low run", lo, (1 << (s + 1)) / 2);
            check_eq("R4 ph2 off", int'(clk_ph2), 0);
            check_eq("R4 ph3 off", int'(clk_ph3), 0);
        end

        // R2: 16 -> 2 mid high half, old high half completes
        begin
            logic p;
            int   guard = 0;
            sample(0, p); sample(0, v);
            while (!(p == 1'b0 && v == 1'b1) && guard < 100) begin p = v; sample(0, v); guard++; end
            hi = 1;
            repeat (2) begin sample(0, v); if (v) hi++; end
            div_sel = 2'd0;
            sample(0, v);
            while (v == 1'b1 && guard < 200) begin hi++; sample(0, v); guard++; end
            check_eq("R2 old high run kept", hi, 8);
            runs(0, hi, lo);
            check_eq("R2 new high run", hi, 1);
            check_eq("R2 new low run", lo, 1);
        end

        // R2: 2 -> 8 at a high sample
        begin
            logic p;
            int   guard = 0;
            sample(0, p); sample(0, v);
            while (!(p == 1'b0 && v == 1'b1) && guard < 100) begin p = v; sample(0, v); guard++; end
            div_sel = 2'd2;
            lo = 0; hi = 0;
            sample(0, v);
            while (v == 1'b0 && guard < 200) begin lo++; sample(0, v); guard++; end
            while (v == 1'b1 && guard < 300) begin hi++; sample(0, v); guard++; end
            check_eq("R2 first new low run", lo, 4);
            check_eq("R2 first new high run", hi, 4);
        end

        // R3 / R9 bypass
        direct_en = 1'b1;
        phase_en  = 1'b1;
        repeat (2) begin
            @(posedge osc_0);   #1250 check_eq("R3 main high", int'(clk_main), 1);
            @(negedge osc_0);   #1250 check_eq("R3 main low", int'(clk_main), 0);
            @(posedge osc_120); #1250 check_eq("R9 ph2 high", int'(clk_ph2), 1);
            @(negedge osc_120); #1250 check_eq("R9 ph2 low", int'(clk_ph2), 0);
            @(posedge osc_240); #1250 check_eq("R9 ph3 high", int'(clk_ph3), 1);
            @(negedge osc_240); #1250 check_eq("R9 ph3 low", int'(clk_ph3), 0);
        end
        direct_en = 1'b0;
        phase_en  = 1'b0;

        // R4 / R5: enable extra phases at an offset, before lock
        div_sel = 2'd3;
        repeat (40) @(negedge osc_0);
        runs(0, hi, lo);
        repeat (4) @(negedge osc_0);
        phase_en = 1'b1;
        repeat (20) @(negedge osc_0);
        runs(1, hi, lo);
        check_eq("R4 ph2 high run", hi, 8);
        check_eq("R4 ph2 low run", lo, 8);
        runs(2, hi, lo);
        check_eq("R4 ph3 high run", hi, 8);
        check_eq("R4 ph3 low run", lo, 8);
        mis = 0;
        compare_for(48, 1'b0);
        check_eq("R5 unaligned before lock", int'(mis > 0), 1);

        // R7 lock latency
        @(negedge osc_0);
        lock_in = 1'b1;
        @(negedge osc_0);
        check_eq("R7 lock after 1 cycle", int'(lock_out), 0);
        @(negedge osc_0);
        check_eq("R7 lock after 2 cycles", int'(lock_out), 1);

        // R5 aligned after lock, also across a select change (R2)
        repeat (40) @(negedge osc_0);
        compare_for(80, 1'b1);
        div_sel = 2'd1;
        compare_for(60, 1'b1);

        // R6 power-down
        @(negedge osc_0);
        pwr_down = 1'b1;
        repeat (10) begin
            @(negedge osc_0);
            check_eq("R6 pd main", int'(clk_main), 0);
            check_eq("R6 pd ph2", int'(clk_ph2), 0);
            check_eq("R6 pd ph3", int'(clk_ph3), 0);
            check_eq("R6 pd lock", int'(lock_out), 0);
        end
        pwr_down = 1'b0;
        @(negedge osc_0);
        check_eq("R7 relock after 1 cycle", int'(lock_out), 0);
        @(negedge osc_0);
        check_eq("R7 relock after 2 cycles", int'(lock_out), 1);
        runs(0, hi, lo);
        check_eq("R6 resume high run", hi, 2);
        check_eq("R6 resume low run", lo, 2);
        repeat (40) @(negedge osc_0);
        compare_for(60, 1'b1);

        // R7 lock loss
        lock_in = 1'b0;
        @(negedge osc_0);
        check_eq("R7 loss after 1 cycle", int'(lock_out), 1);
        @(negedge osc_0);
        check_eq("R7 loss after 2 cycles", int'(lock_out), 0);

        // R8 asynchronous reset in a high half
        div_sel = 2'd3;
        repeat (40) @(negedge osc_0);
        begin
            logic p;
            int   guard = 0;
            sample(0, p); sample(0, v);
            while (!(p == 1'b0 && v == 1'b1) && guard < 100) begin p = v; sample(0, v); guard++; end
        end
        #1000 rst_n = 1'b0;
        #10;
        check_eq("R8 async clk_main", int'(clk_main), 0);
        check_eq("R8 async clk_ph2", int'(clk_ph2), 0);
        check_eq("R8 async clk_ph3", int'(clk_ph3), 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule